// File: doc/BRIEF.md
# Control Response Rate Selector

This block picks the transmit rate for an automatically generated acknowledgement or clear-to-send reply. The host supplies a 16-bit table of basic rates, and the receive path reports the rate of each incoming frame as a one-hot code. When a response is requested, the block returns the fastest enabled basic rate that is not faster than the frame that caused the reply. The result is a one-hot rate code in the same bit assignment, together with a valid flag.

The table mixes two rate families. Bits 0 to 3 hold the four DSSS/CCK rates, bits 8 to 15 hold the eight OFDM rates, and bits 4 to 7 are unused. Candidates are ranked by their real bit rate, not by bit position, so the two families interleave. If no enabled rate is low enough, the block falls back to the slowest enabled rate. If the table is empty, it falls back to 1 Mbit/s. The incoming rate is captured on its own strobe. A response request uses the captured rate and the table as it stands in the request cycle, and the result is registered on the following edge.

Top module: `resp_rate_sel`

## Requirements
- R1: Code bits map to rates as follows: bit 0 = 1, bit 1 = 2, bit 2 = 5.5, bit 3 = 11, bit 8 = 6, bit 9 = 9, bit 10 = 12, bit 11 = 18, bit 12 = 24, bit 13 = 36, bit 14 = 48, bit 15 = 54 Mbit/s. This assignment applies to the table, the incoming code and the output.
- R2: For a legal incoming code, the output is the enabled table rate with the largest bit rate that is less than or equal to the incoming rate.
- R3: Rates are ranked by bit rate across both families. For example, 11 Mbit/s (bit 3) is above 9 Mbit/s (bit 9) and below 12 Mbit/s (bit 10).
- R4: Table bits 4 to 7 have no effect on the result.
- R5: If no enabled rate is at or below the incoming rate, the output is the enabled rate with the smallest bit rate.
- R6: If none of the table bits 0 to 3 or 8 to 15 is set, the output is 1 Mbit/s (bit 0).
- R7: An incoming code is illegal if it has zero bits set, more than one bit set, or any bit in 4 to 7 set. An illegal code yields the R5/R6 fallback.
- R8: The incoming code is captured only in a cycle with `rx_rate_vld` high. `rx_rate` has no effect in any other cycle.
- R9: `resp_vld` is high exactly in the cycle after a cycle with `resp_req` high. That cycle also carries the new `resp_rate`, computed from the table in the request cycle. `resp_rate` holds its value in every other cycle.
- R10: Whenever `resp_vld` is high, `resp_rate` has exactly one bit set, and that bit is outside 4 to 7.
- R11: Reset clears `resp_vld`, `resp_rate` and the captured incoming code, so a request made before any capture yields the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| basic_rates | input | 16 | Basic-rate table from the host |
| rx_rate_vld | input | 1 | Capture strobe for `rx_rate` |
| rx_rate | input | 16 | One-hot rate of the triggering frame |
| resp_req | input | 1 | Request to select a response rate |
| resp_rate | output | 16 | Selected one-hot response rate |
| resp_vld | output | 1 | Result valid, one cycle after a request |

## Verification
The hardest cases to reach are the crossings between the two families. These are tables in which the best candidate sits in the low bits while a numerically higher bit position is slower, or the reverse. Reaching them requires specific mixes of enabled bits relative to the incoming rate. The bench captures each legal incoming rate, plus several illegal codes, and then issues one request per cycle across all 4096 tables built from the twelve meaningful bits. This covers every crossing, every fallback and the empty table, and each result is compared with a reference computed from the bit rates in half-Mbit/s units.

// File: rtl/resp_rate_sel.sv
module resp_rate_sel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] basic_rates,
  input  logic        rx_rate_vld,
  input  logic [15:0] rx_rate,
  input  logic        resp_req,
  output logic [15:0] resp_rate,
  output logic        resp_vld
);
  localparam int          NR    = 12;
  localparam logic [15:0] LEGAL = 16'hFF0F;

  // bit position of the rate with speed rank k (0 = slowest)
  function automatic int pos_of(input int k);
    case (k)
      0: pos_of = 0;   1: pos_of = 1;   2: pos_of = 2;
      3: pos_of = 8;   4: pos_of = 9;   5: pos_of = 3;
      6: pos_of = 10;  7: pos_of = 11;  8: pos_of = 12;
      9: pos_of = 13;  10: pos_of = 14; default: pos_of = 15;
    endcase
  endfunction

  logic [15:0] rate_q;
  logic [NR-1:0] en_r, in_r, le_r, cand;
  logic          in_ok;
  logic [3:0]    hi_idx, lo_idx;
  logic          hi_any;
  logic [15:0]   sel;

  always_ff @(posedge clk) begin
    if (!rst_n) rate_q <= '0;
    else if (rx_rate_vld) rate_q <= rx_rate;
  end

  assign in_ok = ((rate_q & ~LEGAL) == '0) && ($countones(rate_q) == 1);

  for (genvar k = 0; k < NR; k++) begin : g_rank
    assign en_r[k] = basic_rates[pos_of(k)];
    assign in_r[k] = rate_q[pos_of(k)];
    assign le_r[k] = |(in_r >> k);
  end

  assign cand = en_r & le_r & {NR{in_ok}};

  always_comb begin
    hi_any = 1'b0;
    hi_idx = '0;
    for (int k = 0; k < NR; k++)
      if (cand[k]) begin
        hi_any = 1'b1;
        hi_idx = 4'(k);
      end
    lo_idx = '0;
    for (int k = NR - 1; k >= 0; k--)
      if (en_r[k]) lo_idx = 4'(k);
  end

  always_comb begin
    sel = '0;
    if (hi_any)     sel[pos_of(int'(hi_idx))] = 1'b1;
    else if (|en_r) sel[pos_of(int'(lo_idx))] = 1'b1;
    else            sel[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_vld  <= 1'b0;
      resp_rate <= '0;
    end else begin
      resp_vld <= resp_req;
      if (resp_req) resp_rate <= sel;
    end
  end
endmodule

// File: rtl/resp_rate_sel_chk.sv
module resp_rate_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] basic_rates,
  input logic        resp_req,
  input logic [15:0] resp_rate,
  input logic        resp_vld
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_req |=> resp_vld); // R9
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_req |=> !resp_vld); // R9
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_req |=> $stable(resp_rate)); // R9
  AST_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> ($countones(resp_rate) == 1 && resp_rate[7:4] == 4'h0)); // R10
  AST_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_req && (basic_rates & 16'hFF0F) != 16'h0) |=> ((resp_rate & $past(basic_rates)) != 16'h0)); // R2
  AST_EMPTY_1M: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_req && (basic_rates & 16'hFF0F) == 16'h0) |=> (resp_rate == 16'h0001)); // R6
endmodule

bind resp_rate_sel resp_rate_sel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .basic_rates(basic_rates),
  .resp_req(resp_req), .resp_rate(resp_rate), .resp_vld(resp_vld)
);

// File: tb/test_resp_rate_sel.sv
`timescale 1ns/1ps
module test_resp_rate_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] basic_rates = '0;
  logic        rx_rate_vld = 1'b0;
  logic [15:0] rx_rate = '0;
  logic        resp_req = 1'b0;
  logic [15:0] resp_rate;
  logic        resp_vld;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  resp_rate_sel i_resp_rate_sel (
    .clk(clk), .rst_n(rst_n), .basic_rates(basic_rates),
    .rx_rate_vld(rx_rate_vld), .rx_rate(rx_rate),
    .resp_req(resp_req), .resp_rate(resp_rate), .resp_vld(resp_vld)
  );

  function automatic int half_mbps(input int p);
    case (p)
      0: return 2;   1: return 4;   2: return 11;  3: return 22;
      8: return 12;  9: return 18;  10: return 24; 11: return 36;
      12: return 48; 13: return 72; 14: return 96; 15: return 108;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] ref_sel(input logic [15:0] bm, input logic [15:0] rx);
    int in_s, best, bs, lowp, ls, nset;
    bit legal;
    nset = 0; in_s = -1;
    for (int p = 0; p < 16; p++) if (rx[p]) begin
      nset++;
      in_s = half_mbps(p);
    end
    legal = (nset == 1) && (in_s > 0);
    best = -1; bs = 0; lowp = -1; ls = 1000;
    for (int p = 0; p < 16; p++) begin
      if (half_mbps(p) > 0 && bm[p]) begin
        if (legal && half_mbps(p) <= in_s && half_mbps(p) > bs) begin
          best = p; bs = half_mbps(p);
        end
        if (half_mbps(p) < ls) begin
          lowp = p; ls = half_mbps(p);
        end
      end
    end
    if (best >= 0) return 16'(1) << best;
    if (lowp >= 0) return 16'(1) << lowp;
    return 16'h0001;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic capture(input logic [15:0] r);
    rx_rate = r; rx_rate_vld = 1'b1;
    @(negedge clk);
    rx_rate_vld = 1'b0;
  endtask

  task automatic request(input string tag, input logic [15:0] bm, input logic [15:0] exp);
    basic_rates = bm; resp_req = 1'b1;
    @(negedge clk);
    resp_req = 1'b0;
    chk({tag, " vld"}, {15'h0, resp_vld}, 16'h1);
    chk(tag, resp_rate, exp);
  endtask

  initial begin
    #750000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] cur_rx;
    logic [15:0] illegal [4];
    illegal[0] = 16'h0000; illegal[1] = 16'h0101;
    illegal[2] = 16'h0020; illegal[3] = 16'h8008;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 vld", {15'h0, resp_vld}, 16'h0);
    chk("R11 rate", resp_rate, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    request("R11 no capture", 16'h0102, 16'h0002);

    // R1 mapping endpoints
    capture(16'h8000);
    request("R1 54M", 16'hFF0F, 16'h8000);
    capture(16'h0004);
    request("R1 5.5M", 16'hFF0F, 16'h0004);
    // R3 cross-family ordering
    capture(16'h0400);
    request("R3 11 over 9", 16'h0208, 16'h0008);
    request("R3 12 over 11", 16'h0608, 16'h0400);
    capture(16'h0200);
    request("R3 9 below 11", 16'h0209, 16'h0200);
    // R4 unused table bits
    capture(16'h0001);
    request("R4 ignored bits", 16'h00F2, 16'h0002);
    request("R4 only unused", 16'h00F0, 16'h0001);
    // R8 no capture without strobe
    capture(16'h0100);
    rx_rate = 16'h8000;
    @(negedge clk);
    request("R8 ignored rx", 16'hFF0F, 16'h0100);
    // R9 idle after request
    basic_rates = 16'h0001;
    @(negedge clk);
    chk("R9 idle vld", {15'h0, resp_vld}, 16'h0);
    chk("R9 hold", resp_rate, 16'h0100);

    // exhaustive sweep: every legal rate plus illegal codes, every table
    for (int r = 0; r < 16 + 4; r++) begin
      if (r < 16 && half_mbps(r) == 0) continue;
      cur_rx = (r < 16) ? (16'(1) << r) : illegal[r - 16];
      capture(cur_rx);
      resp_req = 1'b1;
      for (int b = 0; b < 4096; b++) begin
        logic [15:0] bm, ex;
        string tag;
        bm = {12'(b) >> 4, 4'h0, 4'(b)};
        basic_rates = bm;
        @(negedge clk);
        ex = ref_sel(bm, cur_rx);
        if (r >= 16) tag = "R7 sweep";
        else if (bm == 16'h0) tag = "R6 sweep";
        else if (ref_sel(bm, cur_rx) == ref_sel(bm, 16'h0)) tag = "R5/R2 sweep";
        else tag = "R2 sweep";
        chk(tag, resp_rate, ex);
        checks++;
        if (!(resp_vld && $countones(resp_rate) == 1 && resp_rate[7:4] == 4'h0)) begin
          errors++;
          $display("FAIL R10: got %h vld %b expected one-hot with vld", resp_rate, resp_vld);
        end
      end
      resp_req = 1'b0;
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule